// File: doc/BRIEF.md
# Byte Data-Bus-Inversion and Write-Mask Codec

This block sits on a 16-bit DDR data path, split into byte lanes, with one side-band DMI line for each lane. Its transmit half looks at each outgoing byte and sends it complemented when it has more ones than zeros. It raises that lane's DMI line to say so, so that at most four of the nine lines of a lane are driven high. On a masked write it uses the DMI line to carry the byte mask instead. When write inversion is on, it sends a masked byte in a form the receiver recognises as "do not write".

The receive half undoes the inversion and produces one write enable per byte. It follows the same rules, so the block can serve either end of the link. Inversion is enabled separately for read data and for write data. Each half has a direction input that says which enable applies to the current transfer. Both halves register their results, with one cycle of latency. Serialization, strobes and pin timing are handled elsewhere.

Top module: `dbi_byte_codec`

## Requirements
- R1: With inversion active for the transfer's direction, a transmitted byte holding five or more ones is sent complemented with its DMI bit high (DMI high means inverted).
- R2: A transmitted byte holding four or fewer ones, including exactly four, is sent unchanged with DMI low.
- R3: Write transfers (direction input 1) use the write-inversion enable and read transfers (direction 0) use the read-inversion enable. With the selected enable off, an unmasked byte is sent unchanged with DMI low.
- R4: On a transmitted masked write with write inversion off, each lane's DMI bit equals that lane's mask bit (1 = do not write), and the data is sent unchanged.
- R5: On a transmitted masked write with write inversion on, a masked byte is sent as all ones with DMI low. Unmasked bytes follow R1 and R2.
- R6: On receive with inversion active, a byte whose DMI bit is high is complemented and a byte whose DMI bit is low passes unchanged. An unmasked transfer asserts every byte enable.
- R7: On a received masked write with write inversion off, DMI high clears that byte's enable, DMI low sets it, and the data passes unchanged.
- R8: On a received masked write with write inversion on, DMI low together with a byte of five or more ones clears that byte's enable. Any other combination sets it, with the data decoded as in R6.
- R9: With inversion off, a received unmasked write or any received read passes the data unchanged and asserts every byte enable, whatever the DMI bits are.
- R10: Each half's outputs and its output valid flag appear one clock after the corresponding input valid. Reset clears all outputs to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_inv_en | input | 1 | Enable inversion on write data |
| rd_inv_en | input | 1 | Enable inversion on read data |
| tx_valid | input | 1 | Transmit input valid |
| tx_is_wr | input | 1 | Transmit transfer is write data (1) or read data (0) |
| tx_masked | input | 1 | Transmit transfer is a masked write |
| tx_data | input | 16 | Raw bytes to send |
| tx_mask | input | 2 | Per-byte mask, 1 = do not write |
| tx_out_valid | output | 1 | Encoded output valid |
| tx_out_data | output | 16 | Encoded bytes |
| tx_out_dmi | output | 2 | Encoded DMI bits |
| rx_valid | input | 1 | Receive input valid |
| rx_is_wr | input | 1 | Received transfer is write data (1) or read data (0) |
| rx_masked | input | 1 | Received transfer is a masked write |
| rx_data | input | 16 | Bytes as received |
| rx_dmi | input | 2 | DMI bits as received |
| rx_out_valid | output | 1 | Decoded output valid |
| rx_out_data | output | 16 | Restored bytes |
| rx_be | output | 2 | Byte write enables, 1 = write |

## Verification
The transmit encoder and the receive decoder run in the same cycle with independent direction, mask mode and data, so one can be in write mode while the other decodes a read. The same cycle can also change which enable each half uses. The bench drives both halves with fresh random values every cycle, plus directed bytes at four and five ones. It predicts each half separately from its own inputs of the previous cycle, so a mix-up between the two enables or the two mask modes shows as a mismatch on one side.

// File: rtl/dbi_byte_codec.sv
module dbi_byte_codec #(
  parameter int LANES  = 2,
  parameter int LANE_W = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_inv_en,
  input  logic                      rd_inv_en,
  input  logic                      tx_valid,
  input  logic                      tx_is_wr,
  input  logic                      tx_masked,
  input  logic [LANES*LANE_W-1:0]   tx_data,
  input  logic [LANES-1:0]          tx_mask,
  output logic                      tx_out_valid,
  output logic [LANES*LANE_W-1:0]   tx_out_data,
  output logic [LANES-1:0]          tx_out_dmi,
  input  logic                      rx_valid,
  input  logic                      rx_is_wr,
  input  logic                      rx_masked,
  input  logic [LANES*LANE_W-1:0]   rx_data,
  input  logic [LANES-1:0]          rx_dmi,
  output logic                      rx_out_valid,
  output logic [LANES*LANE_W-1:0]   rx_out_data,
  output logic [LANES-1:0]          rx_be
);
  localparam int DW   = LANES * LANE_W;
  localparam int CW   = $clog2(LANE_W + 1);
  localparam int HALF = LANE_W / 2;

  function automatic logic [CW-1:0] ones(input logic [LANE_W-1:0] b);
    logic [CW-1:0] n;
    n = '0;
    for (int k = 0; k < LANE_W; k++) n = n + CW'(b[k]);
    return n;
  endfunction

  logic tx_inv, tx_mmode, rx_inv, rx_mmode;
  assign tx_inv   = tx_is_wr ? wr_inv_en : rd_inv_en;
  assign tx_mmode = tx_masked & tx_is_wr;
  assign rx_inv   = rx_is_wr ? wr_inv_en : rd_inv_en;
  assign rx_mmode = rx_masked & rx_is_wr;

  logic [DW-1:0]    tx_nx_data, rx_nx_data;
  logic [LANES-1:0] tx_nx_dmi, rx_nx_be;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [LANE_W-1:0] tb, rb;
    logic tx_heavy, rx_heavy, tx_drop;
    assign tb       = tx_data[i*LANE_W +: LANE_W];
    assign rb       = rx_data[i*LANE_W +: LANE_W];
    assign tx_heavy = ones(tb) > CW'(HALF);
    assign rx_heavy = ones(rb) > CW'(HALF);
    assign tx_drop  = tx_mmode & tx_mask[i];

    assign tx_nx_data[i*LANE_W +: LANE_W] =
      tx_drop ? (tx_inv ? {LANE_W{1'b1}} : tb) :
      (tx_inv && tx_heavy) ? ~tb : tb;
    assign tx_nx_dmi[i] = tx_drop ? ~tx_inv : (tx_inv & tx_heavy);

    assign rx_nx_data[i*LANE_W +: LANE_W] = (rx_inv && rx_dmi[i]) ? ~rb : rb;
    assign rx_nx_be[i] = !rx_mmode ? 1'b1 :
                         rx_inv ? !(!rx_dmi[i] && rx_heavy) : !rx_dmi[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_out_valid <= 1'b0;
      tx_out_data  <= '0;
      tx_out_dmi   <= '0;
      rx_out_valid <= 1'b0;
      rx_out_data  <= '0;
      rx_be        <= '0;
    end else begin
      tx_out_valid <= tx_valid;
      tx_out_data  <= tx_nx_data;
      tx_out_dmi   <= tx_nx_dmi;
      rx_out_valid <= rx_valid;
      rx_out_data  <= rx_nx_data;
      rx_be        <= rx_nx_be;
    end
  end

  p_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |=> tx_out_valid);

  p_rx_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> rx_out_valid);

  p_read_be_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_is_wr) |=> (rx_be == {LANES{1'b1}}));

  p_mask_plain_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_masked && rx_is_wr && !wr_inv_en) |=> (rx_be == ~$past(rx_dmi)));

  p_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_inv && !tx_mmode) |=>
      (tx_out_data == $past(tx_data) && tx_out_dmi == '0));

  for (genvar j = 0; j < LANES; j++) begin : g_chk
    p_inv_light_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && tx_inv) |=>
        (!tx_out_dmi[j] || $countones(tx_out_data[j*LANE_W +: LANE_W]) < HALF));
  end
endmodule

// File: tb/dbi_byte_codec_tb_top.sv
`timescale 1ns/1ps
module dbi_byte_codec_tb_top;
  localparam int LANES = 2;
  localparam int LW    = 8;
  localparam int DW    = LANES * LW;

  logic clk = 0, rst_n = 0;
  logic wr_inv_en = 0, rd_inv_en = 0;
  logic tx_valid = 0, tx_is_wr = 0, tx_masked = 0;
  logic [DW-1:0] tx_data = '0;
  logic [LANES-1:0] tx_mask = '0;
  logic tx_out_valid;
  logic [DW-1:0] tx_out_data;
  logic [LANES-1:0] tx_out_dmi;
  logic rx_valid = 0, rx_is_wr = 0, rx_masked = 0;
  logic [DW-1:0] rx_data = '0;
  logic [LANES-1:0] rx_dmi = '0;
  logic rx_out_valid;
  logic [DW-1:0] rx_out_data;
  logic [LANES-1:0] rx_be;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  dbi_byte_codec #(.LANES(LANES), .LANE_W(LW)) dut_i (.*);

  function automatic int pc(input logic [LW-1:0] b);
    int n = 0;
    for (int k = 0; k < LW; k++) n += b[k];
    return n;
  endfunction

  function automatic logic [DW+LANES-1:0] ref_tx(input logic wr, input logic msk,
      input logic [DW-1:0] d, input logic [LANES-1:0] m, input logic we, input logic re);
    logic [DW-1:0] od; logic [LANES-1:0] odm; logic inv;
    inv = wr ? we : re;
    for (int i = 0; i < LANES; i++) begin
      logic [LW-1:0] b = d[i*LW +: LW];
      if (wr && msk && m[i]) begin
        od[i*LW +: LW] = inv ? 8'hFF : b; odm[i] = !inv;
      end else if (inv && pc(b) >= 5) begin
        od[i*LW +: LW] = ~b; odm[i] = 1'b1;
      end else begin
        od[i*LW +: LW] = b; odm[i] = 1'b0;
      end
    end
    return {odm, od};
  endfunction

  function automatic logic [DW+LANES-1:0] ref_rx(input logic wr, input logic msk,
      input logic [DW-1:0] d, input logic [LANES-1:0] dm, input logic we, input logic re);
    logic [DW-1:0] od; logic [LANES-1:0] be; logic inv;
    inv = wr ? we : re;
    for (int i = 0; i < LANES; i++) begin
      logic [LW-1:0] b = d[i*LW +: LW];
      od[i*LW +: LW] = (inv && dm[i]) ? ~b : b;
      if (!(wr && msk)) be[i] = 1'b1;
      else if (inv) be[i] = !(!dm[i] && pc(b) >= 5);
      else be[i] = !dm[i];
    end
    return {be, od};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(input string ttag, input string rtag);
    logic [DW+LANES-1:0] et, er;
    et = ref_tx(tx_is_wr, tx_masked, tx_data, tx_mask, wr_inv_en, rd_inv_en);
    er = ref_rx(rx_is_wr, rx_masked, rx_data, rx_dmi, wr_inv_en, rd_inv_en);
    @(posedge clk); #1;
    chk({ttag, " tx"}, {tx_out_valid, tx_out_dmi, tx_out_data}, {tx_valid, et});
    chk({rtag, " rx"}, {rx_out_valid, rx_be, rx_out_data}, {rx_valid, er});
    @(negedge clk);
  endtask

  initial begin : wd
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk("R10 reset", {tx_out_valid, tx_out_dmi, tx_out_data, rx_out_valid, rx_be, rx_out_data}, '0);
    rst_n = 1;
    tx_valid = 1; rx_valid = 1;
    // R2: exactly four ones stay plain; R1: five ones invert
    wr_inv_en = 1; tx_is_wr = 1; tx_data = 16'h1F0F; cyc("R1 R2", "R9");
    chk("R1 dmi", tx_out_dmi, 2'b10);
    tx_data = 16'hFF00; cyc("R1", "R9");
    // R3: read direction uses rd enable (off)
    tx_is_wr = 0; tx_data = 16'hFFFE; cyc("R3", "R9");
    rd_inv_en = 1; tx_data = 16'hFFFE; cyc("R3 R1", "R6");
    // R4 / R5 masked transmit
    tx_is_wr = 1; tx_masked = 1; tx_mask = 2'b01; wr_inv_en = 0; tx_data = 16'h7F3C;
    cyc("R4", "R9");
    wr_inv_en = 1; tx_data = 16'h7F3C; cyc("R5", "R9");
    tx_masked = 0;
    // R6 / R7 / R8 / R9 receive
    rx_is_wr = 1; rx_masked = 0; rx_data = 16'hA5C3; rx_dmi = 2'b01; cyc("R3", "R6");
    rx_masked = 1; wr_inv_en = 0; rx_dmi = 2'b10; cyc("R3", "R7");
    wr_inv_en = 1; rx_data = 16'hF80F; rx_dmi = 2'b00; cyc("R1", "R8");
    chk("R8 be", rx_be, 2'b01);
    rx_dmi = 2'b11; cyc("R1", "R8");
    wr_inv_en = 0; rx_masked = 0; rx_dmi = 2'b11; cyc("R3", "R9");
    chk("R9 be", rx_be, 2'b11);
    rx_is_wr = 0; rd_inv_en = 0; rx_dmi = 2'b11; cyc("R3", "R9");
    tx_valid = 0; rx_valid = 0; cyc("R10", "R10");
    for (int n = 0; n < 600; n++) begin
      wr_inv_en = $urandom; rd_inv_en = $urandom;
      tx_valid = $urandom; tx_is_wr = $urandom; tx_masked = $urandom;
      tx_data = $urandom; tx_mask = $urandom;
      rx_valid = $urandom; rx_is_wr = $urandom; rx_masked = $urandom;
      rx_data = $urandom; rx_dmi = $urandom;
      cyc("R1 R2 R3 R4 R5 R10", "R6 R7 R8 R9 R10");
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule